// File: doc/BRIEF.md
# Bidirectional AES-128 Round Key Walker

This block produces the eleven AES-128 round keys one at a time, computing each one when it is needed instead of reading it from a stored schedule. Only one 128-bit key is held at any time, in four 32-bit word registers. A single combinational step unit turns the held key into the next key or into the previous key. The unit shares one four-byte S-box bank between the two directions, so both directions cost about the same logic.

For encryption a start pulse loads the cipher key as round key 0. Each accepted advance then moves one round forward. For decryption the same start pulse loads the cipher key, and the walker then steps forward by itself for ten cycles to reach the last round key. After that it hands out keys from round 10 down to round 0. The key output works as a stream source. `key_valid` marks a key that is on offer. The consumer takes it by raising `advance`, and the transfer happens on any clock edge where both are high. While `advance` is low the offered key and its index stay frozen, so the consumer can hold the walk off for as long as it needs. `advance` has no effect while `key_valid` is low. A start pulse overrides every other input and restarts the walk.

Top module: `aes128_key_walker`

## Requirements
- R1: While reset is asserted and after its release, `key_valid` is 0, `round_idx` is 0 and `round_key` is all zeros, until the first start pulse.
- R2: On the edge where `start` is sampled with `decrypt` = 0, `key_in` is loaded. From that edge on, `key_valid` = 1, `round_idx` = 0 and `round_key` = `key_in`. The word w0 sits in bits 127:96 and w3 in bits 31:0.
- R3: In encrypt mode, each edge with `key_valid` and `advance` high and `round_idx` < 10 moves to the next key of the standard AES-128 expansion, and `round_idx` goes up by one. The rule is: w0 ^= SubWord(RotWord(w3)) ^ (rcon << 24), then each following word is XORed with the new word before it. The rcon sequence for rounds 1 to 10 is 01,02,04,08,10,20,40,80,1B,36.
- R4: On an edge with `key_valid` = 1, `advance` = 0 and `start` = 0, `round_key`, `round_idx` and `key_valid` keep their values. This holds in both modes.
- R5: On the edge where `start` is sampled with `decrypt` = 1, `key_valid` drops to 0. It stays 0 for exactly 10 cycles while the walker steps forward internally. It then rises with `round_idx` = 10 and `round_key` equal to the round-10 key.
- R6: In decrypt mode, each edge with `key_valid` and `advance` high and `round_idx` > 0 recovers the previous round key, and `round_idx` goes down by one. The walk ends with `round_key` equal to the cipher key at index 0.
- R7: An accepted advance on the last key of a walk (index 10 when encrypting, index 0 when decrypting) clears `key_valid`. The held key and the index stay as they were.
- R8: `advance` has no effect while `key_valid` is 0. When idle, the outputs do not change. During the forward pre-scheduling pass, the pass still takes exactly 10 cycles and lands on the round-10 key.
- R9: A start pulse in the middle of a walk takes priority over `advance` and restarts from round 0 in the newly chosen mode, using the newly presented key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_in | input | 128 | Cipher key, sampled on the start edge |
| start | input | 1 | Load key and begin a walk |
| decrypt | input | 1 | Walk direction, sampled with start: 1 = reverse order |
| advance | input | 1 | Consumer accepts the offered key |
| round_key | output | 128 | Current round key, w0 in the top word |
| round_idx | output | 4 | Round number of `round_key` |
| key_valid | output | 1 | A round key is on offer |

## Verification
Every output is registered, so each result can be seen one edge after the input that causes it. The bench drives on the falling edge and samples on the next falling edge. Round 0 of an encrypt walk and every advance step can therefore be checked right after the edge that produced them. For a decrypt start, `key_valid` is sampled low at each of the nine falling edges after the start edge. It is then checked high, with index 10 and the round-10 key, after the tenth edge that follows the start edge. `advance` is held high through that window to show it is ignored there. Both walks are compared against the known expansion of the standard 2b7e1516... test key.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;

  typedef enum logic [1:0] {
    PH_IDLE     = 2'd0,
    PH_PRESCHED = 2'd1,
    PH_LIVE     = 2'd2
  } ks_phase_e;

  // multiply by x in GF(2^8), reduction polynomial x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (8'h1b & {8{a[7]}});
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  // a^254 equals the multiplicative inverse, and maps 0 to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] res;
    logic [7:0] pw;
    res = 8'h01;
    pw  = a;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) res = gf_mul(res, pw);
      pw = gf_mul(pw, pw);
    end
    return res;
  endfunction

  function automatic logic [7:0] sbox_affine(input logic [7:0] b);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
             ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

  // round constant for round n (n >= 1): x^(n-1) in GF(2^8)
  function automatic logic [7:0] rcon_byte(input logic [7:0] n);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 1; i < 32; i++) begin
      if (i < int'(n)) r = gf_xtime(r);
    end
    return r;
  endfunction

endpackage

// File: rtl/ks_sbox.sv
module ks_sbox
  import aes_ks_pkg::*;
(
  input  logic [7:0] din,
  output logic [7:0] dout
);
  assign dout = sbox_affine(gf_inv(din));
endmodule

// File: rtl/ks_subword.sv
module ks_subword #(
  parameter int WORD_W = 32,
  localparam int NBYTES = WORD_W / 8
) (
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    ks_sbox u_sbox (
      .din  (din[b*8 +: 8]),
      .dout (dout[b*8 +: 8])
    );
  end
endmodule

// File: rtl/ks_step.sv
module ks_step #(
  parameter int WORD_W = 32,
  parameter int NWORDS = 4,
  localparam int KEY_W = WORD_W * NWORDS
) (
  input  logic [KEY_W-1:0] cur_key,
  input  logic             rev,
  input  logic [7:0]       rc,
  output logic [KEY_W-1:0] nxt_key
);
  logic [WORD_W-1:0] cw [NWORDS];
  logic [WORD_W-1:0] fw [NWORDS];
  logic [WORD_W-1:0] bw [NWORDS];
  logic [WORD_W-1:0] sub_in;
  logic [WORD_W-1:0] rot_w;
  logic [WORD_W-1:0] sub_out;
  logic [WORD_W-1:0] tmix;

  for (genvar i = 0; i < NWORDS; i++) begin : g_unpack
    assign cw[i] = cur_key[(NWORDS-1-i)*WORD_W +: WORD_W];
    assign nxt_key[(NWORDS-1-i)*WORD_W +: WORD_W] = rev ? bw[i] : fw[i];
  end

  // forward: last word as held; reverse: last word recovered from the newer key
  assign sub_in = rev ? (cw[NWORDS-1] ^ cw[NWORDS-2]) : cw[NWORDS-1];
  assign rot_w  = {sub_in[WORD_W-9:0], sub_in[WORD_W-1 -: 8]};

  ks_subword #(.WORD_W(WORD_W)) u_subword (
    .din  (rot_w),
    .dout (sub_out)
  );

  assign tmix = sub_out ^ {rc, {(WORD_W-8){1'b0}}};

  assign fw[0] = cw[0] ^ tmix;
  assign bw[0] = cw[0] ^ tmix;
  for (genvar i = 1; i < NWORDS; i++) begin : g_chain
    assign fw[i] = cw[i] ^ fw[i-1];
    assign bw[i] = cw[i] ^ cw[i-1];
  end
endmodule

// File: rtl/ks_ctrl.sv
module ks_ctrl
  import aes_ks_pkg::*;
#(
  parameter int NR = 10,
  localparam int IDX_W = $clog2(NR + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             decrypt,
  input  logic             advance,
  output logic             load,
  output logic             step_en,
  output logic             step_rev,
  output logic             walk_rev,
  output logic [IDX_W-1:0] idx,
  output logic             live
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NR);

  ks_phase_e phase;
  logic      at_end;

  assign live     = (phase == PH_LIVE);
  assign at_end   = walk_rev ? (idx == '0) : (idx == LAST);
  assign load     = start;
  assign step_rev = live && walk_rev;
  assign step_en  = !start && ((phase == PH_PRESCHED) || (live && advance && !at_end));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      idx      <= '0;
      walk_rev <= 1'b0;
    end else if (start) begin
      phase    <= decrypt ? PH_PRESCHED : PH_LIVE;
      idx      <= '0;
      walk_rev <= decrypt;
    end else begin
      case (phase)
        PH_PRESCHED: begin
          idx <= idx + 1'b1;
          if (idx == LAST - 1'b1) phase <= PH_LIVE;
        end
        PH_LIVE: begin
          if (advance) begin
            if (at_end)        phase <= PH_IDLE;
            else if (walk_rev) idx <= idx - 1'b1;
            else               idx <= idx + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/aes128_key_walker.sv
module aes128_key_walker
  import aes_ks_pkg::*;
#(
  parameter int NR = 10,
  parameter int WORD_W = 32,
  localparam int NWORDS = 4,
  localparam int KEY_W = NWORDS * WORD_W,
  localparam int IDX_W = $clog2(NR + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] key_in,
  input  logic             start,
  input  logic             decrypt,
  input  logic             advance,
  output logic [KEY_W-1:0] round_key,
  output logic [IDX_W-1:0] round_idx,
  output logic             key_valid
);
  logic             load;
  logic             step_en;
  logic             step_rev;
  logic             walk_rev;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] rc_idx;
  logic [7:0]       rc;
  logic [KEY_W-1:0] nxt_key;

  ks_ctrl #(.NR(NR)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .decrypt  (decrypt),
    .advance  (advance),
    .load     (load),
    .step_en  (step_en),
    .step_rev (step_rev),
    .walk_rev (walk_rev),
    .idx      (idx),
    .live     (key_valid)
  );

  // forward step into round idx+1 uses its constant; backward out of idx uses idx's
  assign rc_idx = step_rev ? idx : idx + 1'b1;
  assign rc     = rcon_byte(8'(rc_idx));

  ks_step #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_step (
    .cur_key (round_key),
    .rev     (step_rev),
    .rc      (rc),
    .nxt_key (nxt_key)
  );

  // one register per word, each behind its own load/update mux
  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        round_key[w*WORD_W +: WORD_W] <= '0;
      else if (load)
        round_key[w*WORD_W +: WORD_W] <= key_in[w*WORD_W +: WORD_W];
      else if (step_en)
        round_key[w*WORD_W +: WORD_W] <= nxt_key[w*WORD_W +: WORD_W];
    end
  end

  assign round_idx = idx;
endmodule

// File: rtl/aes128_key_walker_chk.sv
module aes128_key_walker_chk #(
  parameter int NR = 10,
  parameter int KEY_W = 128,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             decrypt,
  input logic             advance,
  input logic [KEY_W-1:0] key_in,
  input logic [KEY_W-1:0] round_key,
  input logic [IDX_W-1:0] round_idx,
  input logic             key_valid,
  input logic             walk_rev
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NR);
  localparam logic [IDX_W:0]   CMAX = '1;

  logic [IDX_W:0] pre_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           pre_cnt <= '0;
    else if (start)                       pre_cnt <= '0;
    else if (!key_valid && pre_cnt != CMAX) pre_cnt <= pre_cnt + 1'b1;
  end

  p_enc_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !decrypt |=> key_valid && round_idx == '0 && round_key == $past(key_in));

  p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    round_idx <= LAST);

  p_fwd_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid && advance && !start && !walk_rev && round_idx != LAST
    |=> key_valid && round_idx == $past(round_idx) + 1'b1);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid && !advance && !start
    |=> key_valid && $stable(round_key) && $stable(round_idx));

  p_dec_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start && decrypt |=> !key_valid && round_idx == '0);

  p_presched_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_valid) && walk_rev |-> pre_cnt == (IDX_W+1)'(NR) && round_idx == LAST);

  p_rev_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid && advance && !start && walk_rev && round_idx != '0
    |=> key_valid && round_idx == $past(round_idx) - 1'b1);

  p_walk_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid && advance && !start
    && (walk_rev ? (round_idx == '0) : (round_idx == LAST))
    |=> !key_valid && $stable(round_key) && $stable(round_idx));
endmodule

bind aes128_key_walker aes128_key_walker_chk #(
  .NR(NR), .KEY_W(KEY_W), .IDX_W(IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .decrypt   (decrypt),
  .advance   (advance),
  .key_in    (key_in),
  .round_key (round_key),
  .round_idx (round_idx),
  .key_valid (key_valid),
  .walk_rev  (walk_rev)
);

// File: tb/aes128_key_walker_test.sv
module aes128_key_walker_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] key_in = '0;
  logic         start = 1'b0;
  logic         decrypt = 1'b0;
  logic         advance = 1'b0;
  logic [127:0] round_key;
  logic [3:0]   round_idx;
  logic         key_valid;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  localparam logic [127:0] ROUND_KEYS [0:10] = '{
    128'h2b7e151628aed2a6abf7158809cf4f3c,
    128'ha0fafe1788542cb123a339392a6c7605,
    128'hf2c295f27a96b9435935807a7359f67f,
    128'h3d80477d4716fe3e1e237e446d7a883b,
    128'hef44a541a8525b7fb671253bdb0bad00,
    128'hd4d1c6f87c839d87caf2b8bc11f915bc,
    128'h6d88a37a110b3efddbf98641ca0093fd,
    128'h4e54f70e5f5fc9f384a64fb24ea6dc4f,
    128'head27321b58dbad2312bf5607f8d292f,
    128'hac7766f319fadc2128d12941575c006e,
    128'hd014f9a8c9ee2589e13f0cc8b6630ca6
  };
  localparam logic [127:0] ALT_KEY = 128'h000102030405060708090a0b0c0d0e0f;

  aes128_key_walker uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_in    (key_in),
    .start     (start),
    .decrypt   (decrypt),
    .advance   (advance),
    .round_key (round_key),
    .round_idx (round_idx),
    .key_valid (key_valid)
  );

  always #5 clk = ~clk;

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic vld,
                           input logic [3:0] idx, input logic [127:0] key);
    check(req, "key_valid", 128'(key_valid), 128'(vld));
    check(req, "round_idx", 128'(round_idx), 128'(idx));
    check(req, "round_key", round_key, key);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) step();
    check_out("R1", 1'b0, 4'd0, '0);
    rst_n = 1'b1;
    step();
    check_out("R1", 1'b0, 4'd0, '0);

    // R8: advance while idle changes nothing
    advance = 1'b1;
    repeat (2) step();
    check_out("R8", 1'b0, 4'd0, '0);
    advance = 1'b0;

    // R2: encrypt start
    key_in = ROUND_KEYS[0]; decrypt = 1'b0; start = 1'b1;
    step();
    start = 1'b0;
    check_out("R2", 1'b1, 4'd0, ROUND_KEYS[0]);

    // R4: hold with advance low
    repeat (3) step();
    check_out("R4", 1'b1, 4'd0, ROUND_KEYS[0]);

    // R3: forward walk against the table
    advance = 1'b1;
    for (int r = 1; r <= 10; r++) begin
      step();
      check_out("R3", 1'b1, 4'(r), ROUND_KEYS[r]);
    end
    // R7: accepting the last key ends the walk, key held
    step();
    check_out("R7", 1'b0, 4'd10, ROUND_KEYS[10]);

    // R5 / R8: decrypt start, advance held high through pre-scheduling
    decrypt = 1'b1; start = 1'b1;
    step();
    start = 1'b0;
    check("R5", "key_valid after start", 128'(key_valid), 128'(0));
    for (int c = 1; c <= 9; c++) begin
      step();
      check("R5", "key_valid in pre-schedule", 128'(key_valid), 128'(0));
    end
    step();
    check_out("R5", 1'b1, 4'd10, ROUND_KEYS[10]);
    check("R8", "pre-schedule landed on last key", round_key, ROUND_KEYS[10]);

    // R4: hold in reverse mode
    advance = 1'b0;
    repeat (2) step();
    check_out("R4", 1'b1, 4'd10, ROUND_KEYS[10]);

    // R6: backward walk
    advance = 1'b1;
    for (int r = 9; r >= 0; r--) begin
      step();
      check_out("R6", 1'b1, 4'(r), ROUND_KEYS[r]);
    end
    step();
    check_out("R7", 1'b0, 4'd0, ROUND_KEYS[0]);

    // R9: restart mid-walk, start beats advance
    decrypt = 1'b0; start = 1'b1; key_in = ROUND_KEYS[0];
    step();
    start = 1'b0;
    check_out("R9", 1'b1, 4'd0, ROUND_KEYS[0]);
    repeat (3) step();
    check_out("R3", 1'b1, 4'd3, ROUND_KEYS[3]);
    key_in = ALT_KEY; start = 1'b1;
    step();
    check_out("R9", 1'b1, 4'd0, ALT_KEY);
    decrypt = 1'b1; key_in = ROUND_KEYS[0];
    step();
    start = 1'b0; advance = 1'b0;
    check("R9", "key_valid after decrypt restart", 128'(key_valid), 128'(0));
    check("R9", "round_idx after decrypt restart", 128'(round_idx), 128'(0));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule